// File: doc/BRIEF.md
# Indirect-Indexed Bus Cycle Sequencer

This block produces the bus cycles that an 8-bit processor generates for its zero-page indirect, Y-indexed addressing mode. It makes one memory access on every clock, with no idle bus cycles. Each access is to the program counter, to zero page or to the computed effective address. A start pulse carries the program counter, the Y index and the access kind. The sequencer then fetches the opcode and the operand and reads the two pointer bytes from zero page. It adds Y to the low pointer byte only and reads at the address that this partial sum gives.

That first effective read is speculative: the carry of the low-byte add is not yet in the high byte. For a plain read with no carry, the speculative read is the final access. Otherwise a fix-up cycle repeats the access with the high byte incremented by the carry. Stores and read-modify-write operations always take the fix-up cycle, so no write ever reaches an uncorrected address. A read-modify-write first writes the unmodified value back, then writes the new result. The result for a store comes from an external datapath on `wr_result`. Instruction decode, ALU work and flags are outside this block.

Top module: `ptr_idx_seq`

## Requirements
- R1: Reset and idle. After reset, and on every cycle with no operation in progress, the block performs a read at address 0 with `done` low.
- R2: Start and fetches. A start pulse seen in an idle cycle is accepted. The next cycle reads the opcode at `start_pc`, and the cycle after that reads the operand at `start_pc+1`.
- R3: Pointer reads. The third access reads the pointer low byte at address {0x00, operand}. The fourth reads the pointer high byte at {0x00, (operand+1) mod 256}, so the pointer never leaves zero page.
- R4: Speculative read. The fifth access is always a read at {pointer_high, (pointer_low+Y) mod 256}, with no carry into the high byte. Y is the value captured with the start pulse.
- R5: Read kind. `start_kind` 0 selects a read, and code 3 behaves as 0. With no carry out of the low-byte add, the speculative read is final (5 cycles). With a carry, a sixth read goes to {(pointer_high+1) mod 256, same low byte} and is final.
- R6: Write kind. `start_kind` 1 selects a write. The speculative access is a read. The sixth access is always a write of `wr_result` to the corrected address, even when no carry occurred.
- R7: Read-modify-write kind. `start_kind` 2 selects a read-modify-write. After the speculative read it reads the corrected address, writes that value back unchanged, then writes `wr_result` there: 8 accesses in all.
- R8: Done and busy. `done` is high for exactly the one cycle of the final access, and the cycle after it is idle. A start pulse arriving while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| start_kind | input | 2 | Access kind: 0 read, 1 write, 2 read-modify-write, 3 read |
| start_pc | input | 16 | Address of the opcode |
| start_y | input | 8 | Index value added to the pointer |
| wr_result | input | 8 | Value to store, sampled in the cycle before each store of it |
| bus_din | input | 8 | Read data, valid within the access cycle |
| bus_addr | output | 16 | Address of the current access |
| bus_dout | output | 8 | Write data of the current access |
| bus_rnw | output | 1 | 1 for a read access, 0 for a write access |
| done | output | 1 | High during the final access of an operation |

## Verification
All bus outputs are registered. A start pulse seen at a rising edge therefore makes the opcode fetch appear on the bus in the very next cycle, and each later access follows one cycle after the one before it. `done` rises with the 5th, 6th or 8th access, depending on the kind and on the carry. The driver raises start just after a falling edge. At the same moment it queues the full expected access list, one entry per cycle, computed from the pointer bytes, Y and the carry. The monitor takes one entry off the queue at each later falling edge and compares address, direction, write data and `done`. When the queue is empty it expects the idle read at address 0, which also proves that a start pulse during a busy operation added no cycles.

// File: rtl/ixs_pkg.sv
package ixs_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_RMW   = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_OPR,
    ST_PLO,
    ST_PHI,
    ST_EFF,
    ST_FIX,
    ST_DWB,
    ST_FWB
  } phase_e;

  function automatic kind_e kind_decode(input logic [1:0] raw);
    kind_e k;
    case (raw)
      2'd1:    k = KIND_WRITE;
      2'd2:    k = KIND_RMW;
      default: k = KIND_READ;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/ixs_lo_add.sv
module ixs_lo_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         co
);
  logic [W:0] full;
  always_comb begin
    full = {1'b0, a} + {1'b0, b};
    sum  = full[W-1:0];
    co   = full[W];
  end
endmodule

// File: rtl/ixs_ctrl.sv
module ixs_ctrl (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [1:0]     start_kind,
  input  logic           carry_nxt,
  output ixs_pkg::phase_e state_q,
  output ixs_pkg::phase_e nxt_state,
  output ixs_pkg::kind_e  kind_q,
  output logic           final_d
);
  import ixs_pkg::*;

  // phase sequencing
  always_comb begin
    nxt_state = state_q;
    case (state_q)
      ST_IDLE: nxt_state = start ? ST_OPC : ST_IDLE;
      ST_OPC:  nxt_state = ST_OPR;
      ST_OPR:  nxt_state = ST_PLO;
      ST_PLO:  nxt_state = ST_PHI;
      ST_PHI:  nxt_state = ST_EFF;
      ST_EFF:  nxt_state = (kind_q == KIND_READ && !carry_nxt) ? ST_IDLE : ST_FIX;
      ST_FIX:  nxt_state = (kind_q == KIND_RMW) ? ST_DWB : ST_IDLE;
      ST_DWB:  nxt_state = ST_FWB;
      ST_FWB:  nxt_state = ST_IDLE;
      default: nxt_state = ST_IDLE;
    endcase
  end

  // the phase being entered carries the last access of the operation
  always_comb begin
    case (nxt_state)
      ST_EFF:  final_d = (kind_q == KIND_READ) && !carry_nxt;
      ST_FIX:  final_d = (kind_q != KIND_RMW);
      ST_FWB:  final_d = 1'b1;
      default: final_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_READ;
    end else begin
      state_q <= nxt_state;
      if (state_q == ST_IDLE && start) kind_q <= kind_decode(start_kind);
    end
  end

  AST_KIND_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(kind_q)); // R8

  AST_OPC_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPC) |-> ($past(state_q) == ST_IDLE && $past(start))); // R2

endmodule

// File: rtl/ixs_path.sv
module ixs_path #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ixs_pkg::phase_e   state_q,
  input  ixs_pkg::phase_e   nxt_state,
  input  ixs_pkg::kind_e    kind_q,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic [DATA_W-1:0] start_y,
  input  logic [DATA_W-1:0] bus_din,
  input  logic [DATA_W-1:0] wr_result,
  output logic              carry_nxt,
  output logic [ADDR_W-1:0] addr_d,
  output logic              rnw_d,
  output logic              dout_we,
  output logic [DATA_W-1:0] dout_d
);
  import ixs_pkg::*;

  localparam logic [DATA_W-1:0] ZERO_PAGE = '0;
  localparam logic [DATA_W-1:0] ONE_B     = DATA_W'(1);
  localparam logic [ADDR_W-1:0] ONE_A     = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] y_q;
  logic [DATA_W-1:0] zp_q;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] hi_q;
  logic [DATA_W-1:0] sum_q;
  logic              carry_q;
  logic [DATA_W-1:0] add_sum;
  logic              add_co;
  logic [DATA_W-1:0] eff_hi;

  ixs_lo_add #(.W(DATA_W)) u_lo_add (
    .a   (lo_q),
    .b   (y_q),
    .sum (add_sum),
    .co  (add_co)
  );

  // operand, pointer and sum capture
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      y_q     <= '0;
      zp_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      sum_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (state_q == ST_IDLE && nxt_state == ST_OPC) begin
        pc_q <= start_pc;
        y_q  <= start_y;
      end
      case (state_q)
        ST_OPR: zp_q <= bus_din;
        ST_PLO: lo_q <= bus_din;
        ST_PHI: begin
          hi_q    <= bus_din;
          sum_q   <= add_sum;
          carry_q <= add_co;
        end
        default: ;
      endcase
    end
  end

  assign carry_nxt = (state_q == ST_PHI) ? add_co : carry_q;
  assign eff_hi    = hi_q + {{(DATA_W-1){1'b0}}, carry_q};

  // address of the access in the phase being entered
  always_comb begin
    case (nxt_state)
      ST_OPC:                 addr_d = start_pc;
      ST_OPR:                 addr_d = pc_q + ONE_A;
      ST_PLO:                 addr_d = {ZERO_PAGE, bus_din};
      ST_PHI:                 addr_d = {ZERO_PAGE, zp_q + ONE_B};
      ST_EFF:                 addr_d = {bus_din, add_sum};
      ST_FIX, ST_DWB, ST_FWB: addr_d = {eff_hi, sum_q};
      default:                addr_d = '0;
    endcase
  end

  always_comb begin
    rnw_d   = !((nxt_state == ST_FIX && kind_q == KIND_WRITE) ||
                nxt_state == ST_DWB || nxt_state == ST_FWB);
    dout_we = !rnw_d;
    dout_d  = (nxt_state == ST_DWB) ? bus_din : wr_result;
  end

endmodule

// File: rtl/ixs_busreg.sv
module ixs_busreg #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              rnw_d,
  input  logic              dout_we,
  input  logic [DATA_W-1:0] dout_d,
  input  logic              final_d,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rnw_q,
  output logic [DATA_W-1:0] dout_q,
  output logic              done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      rnw_q  <= 1'b1;
      dout_q <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      rnw_q  <= rnw_d;
      done_q <= final_d;
      if (dout_we) dout_q <= dout_d;
    end
  end
endmodule

// File: rtl/ptr_idx_seq.sv
module ptr_idx_seq #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        start_kind,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic [DATA_W-1:0] start_y,
  input  logic [DATA_W-1:0] wr_result,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_rnw,
  output logic              done
);
  import ixs_pkg::*;

  localparam logic [DATA_W-1:0] ONE_B = DATA_W'(1);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

  phase_e            state_q;
  phase_e            nxt_state;
  kind_e             kind_q;
  logic              final_d;
  logic              carry_nxt;
  logic [ADDR_W-1:0] addr_d;
  logic              rnw_d;
  logic              dout_we;
  logic [DATA_W-1:0] dout_d;

  ixs_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_kind (start_kind),
    .carry_nxt  (carry_nxt),
    .state_q    (state_q),
    .nxt_state  (nxt_state),
    .kind_q     (kind_q),
    .final_d    (final_d)
  );

  ixs_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_q),
    .nxt_state (nxt_state),
    .kind_q    (kind_q),
    .start_pc  (start_pc),
    .start_y   (start_y),
    .bus_din   (bus_din),
    .wr_result (wr_result),
    .carry_nxt (carry_nxt),
    .addr_d    (addr_d),
    .rnw_d     (rnw_d),
    .dout_we   (dout_we),
    .dout_d    (dout_d)
  );

  ixs_busreg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_busreg (
    .clk     (clk),
    .rst     (rst),
    .addr_d  (addr_d),
    .rnw_d   (rnw_d),
    .dout_we (dout_we),
    .dout_d  (dout_d),
    .final_d (final_d),
    .addr_q  (bus_addr),
    .rnw_q   (bus_rnw),
    .dout_q  (bus_dout),
    .done_q  (done)
  );

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (bus_addr == '0 && bus_rnw && !done)); // R1

  AST_OPERAND_AFTER_OPCODE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPR) |-> (bus_addr == $past(bus_addr) + ONE_A)); // R2

  AST_PTR_HIGH_IN_ZP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PHI) |-> (bus_addr[ADDR_W-1:DATA_W] == '0 &&
      bus_addr[DATA_W-1:0] == $past(bus_addr[DATA_W-1:0]) + ONE_B)); // R3

  AST_SPECULATIVE_IS_READ: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EFF) |-> bus_rnw); // R4

  AST_FIXUP_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIX) |-> (bus_addr[DATA_W-1:0] == $past(bus_addr[DATA_W-1:0]))); // R5

  AST_WRITE_ONLY_CORRECTED: assert property (@(posedge clk) disable iff (rst)
    !bus_rnw |-> (state_q == ST_FIX || state_q == ST_DWB || state_q == ST_FWB)); // R6

  AST_DUMMY_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DWB) |-> (!bus_rnw && bus_dout == $past(bus_din))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && state_q == ST_IDLE)); // R8

endmodule

// File: tb/test_ptr_idx_seq.sv
`timescale 1ns/1ps
module test_ptr_idx_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  start_kind = 2'd0;
  logic [15:0] start_pc = 16'h0;
  logic [7:0]  start_y = 8'h0;
  logic [7:0]  wr_result = 8'h0;
  logic [7:0]  bus_din;
  logic [15:0] bus_addr;
  logic [7:0]  bus_dout;
  logic        bus_rnw;
  logic        done;

  logic [15:0] cur_pc = 16'h8000;
  logic [7:0]  cur_opr = 8'h00, cur_lo = 8'h00, cur_hi = 8'h00;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] a;
    logic        rnw;
    logic [7:0]  d;
    bit          chk_d;
    logic        dn;
    string       tag;
  } item_t;

  item_t exp_q[$];
  item_t it;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_rd(input logic [15:0] a, input logic [15:0] pc,
                                        input logic [7:0] opr, input logic [7:0] lo,
                                        input logic [7:0] hi);
    if (a == pc + 16'd1)                   return opr;
    else if (a == {8'h00, opr})            return lo;
    else if (a == {8'h00, opr + 8'd1})     return hi;
    else if (a == pc)                      return 8'hB1;
    else                                   return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
  endfunction

  assign bus_din = mem_rd(bus_addr, cur_pc, cur_opr, cur_lo, cur_hi);

  ptr_idx_seq i_ptr_idx_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_kind (start_kind),
    .start_pc   (start_pc),
    .start_y    (start_y),
    .wr_result  (wr_result),
    .bus_din    (bus_din),
    .bus_addr   (bus_addr),
    .bus_dout   (bus_dout),
    .bus_rnw    (bus_rnw),
    .done       (done)
  );

  task automatic push(input logic [15:0] a, input logic rnw, input logic [7:0] d,
                      input bit chk_d, input logic dn, input string tag);
    item_t e;
    e.a = a; e.rnw = rnw; e.d = d; e.chk_d = chk_d; e.dn = dn; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: one expected access per cycle, idle read when nothing is queued
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      checks++;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        if (bus_addr !== it.a || bus_rnw !== it.rnw || done !== it.dn ||
            (it.chk_d && bus_dout !== it.d)) begin
          errors++;
          $display("FAIL %s: addr=%h rnw=%b dout=%h done=%b expected addr=%h rnw=%b dout=%h done=%b",
                   it.tag, bus_addr, bus_rnw, bus_dout, done, it.a, it.rnw, it.d, it.dn);
        end
      end else if (bus_addr !== 16'h0 || bus_rnw !== 1'b1 || done !== 1'b0) begin
        errors++;
        $display("FAIL R1 idle: addr=%h rnw=%b done=%b expected addr=0000 rnw=1 done=0",
                 bus_addr, bus_rnw, done);
      end
    end
  end

  // driver: queue every access of one operation and pulse start
  task automatic run_op(input logic [1:0] k, input logic [15:0] pc, input logic [7:0] opr,
                        input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] y,
                        input logic [7:0] res, input bit poke_busy);
    logic [8:0]  s;
    logic [15:0] eu, ec;
    logic        c;
    @(negedge clk); #1;
    cur_pc = pc; cur_opr = opr; cur_lo = lo; cur_hi = hi;
    wr_result = res;
    s  = {1'b0, lo} + {1'b0, y};
    c  = s[8];
    eu = {hi, s[7:0]};
    ec = {hi + {7'd0, c}, s[7:0]};
    push(pc,                 1'b1, 8'h00, 1'b0, 1'b0, "R2 opcode fetch");
    push(pc + 16'd1,         1'b1, 8'h00, 1'b0, 1'b0, "R2 operand fetch");
    push({8'h00, opr},       1'b1, 8'h00, 1'b0, 1'b0, "R3 pointer low");
    push({8'h00, opr + 8'd1},1'b1, 8'h00, 1'b0, 1'b0, "R3 pointer high");
    if (k == 2'd1) begin
      push(eu, 1'b1, 8'h00, 1'b0, 1'b0, "R4 speculative read (write kind)");
      push(ec, 1'b0, res,   1'b1, 1'b1, "R6 corrected write");
    end else if (k == 2'd2) begin
      push(eu, 1'b1, 8'h00, 1'b0, 1'b0, "R4 speculative read (rmw)");
      push(ec, 1'b1, 8'h00, 1'b0, 1'b0, "R7 corrected read");
      push(ec, 1'b0, mem_rd(ec, pc, opr, lo, hi), 1'b1, 1'b0, "R7 unmodified write-back");
      push(ec, 1'b0, res,   1'b1, 1'b1, "R7 result write");
    end else if (!c) begin
      push(eu, 1'b1, 8'h00, 1'b0, 1'b1, "R5 read final without carry");
    end else begin
      push(eu, 1'b1, 8'h00, 1'b0, 1'b0, "R4 speculative read (carry)");
      push(ec, 1'b1, 8'h00, 1'b0, 1'b1, "R5 fix-up read");
    end
    start_kind = k; start_pc = pc; start_y = y; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; start_pc = ~pc; start_y = ~y; start_kind = ~k;
    if (poke_busy) begin
      // R8: start while busy must add nothing to the queued access list
      repeat (2) @(posedge clk);
      #1 start = 1'b1; start_kind = 2'd1;
      @(posedge clk); #1 start = 1'b0;
    end
    wait (exp_q.size() == 0);
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (bus_addr !== 16'h0 || bus_rnw !== 1'b1 || done !== 1'b0 || bus_dout !== 8'h0) begin
      errors++;
      $display("FAIL R1 reset: addr=%h rnw=%b done=%b dout=%h expected addr=0000 rnw=1 done=0 dout=00",
               bus_addr, bus_rnw, done, bus_dout);
    end
    #1 rst = 1'b0;
    mon_on = 1'b1;
    repeat (2) @(posedge clk);

    run_op(2'd0, 16'h8000, 8'h40, 8'h10, 8'h30, 8'h05, 8'h00, 1'b0); // R5 no carry
    run_op(2'd0, 16'h8102, 8'h42, 8'hF0, 8'h30, 8'h20, 8'h00, 1'b0); // R5 carry
    run_op(2'd0, 16'h8204, 8'h50, 8'h80, 8'hFF, 8'h80, 8'h00, 1'b0); // R5 high byte wraps
    run_op(2'd0, 16'h8306, 8'h60, 8'hFF, 8'h12, 8'h00, 8'h00, 1'b0); // R4 zero index
    run_op(2'd0, 16'h8408, 8'hFF, 8'h34, 8'h22, 8'h01, 8'h00, 1'b0); // R3 zero-page wrap
    run_op(2'd3, 16'h850A, 8'h70, 8'hE0, 8'h24, 8'h30, 8'h00, 1'b0); // R5 code 3 as read
    run_op(2'd1, 16'h860C, 8'h72, 8'h10, 8'h26, 8'h05, 8'h5C, 1'b0); // R6 no carry
    run_op(2'd1, 16'h870E, 8'h74, 8'hC0, 8'h28, 8'h41, 8'h9D, 1'b0); // R6 carry
    run_op(2'd2, 16'h8810, 8'h76, 8'h20, 8'h2A, 8'h11, 8'h3E, 1'b0); // R7 no carry
    run_op(2'd2, 16'h8912, 8'h78, 8'hFE, 8'h2C, 8'h02, 8'h7F, 1'b0); // R7 carry
    run_op(2'd2, 16'h8A14, 8'h7A, 8'h08, 8'h2E, 8'h09, 8'hC4, 1'b1); // R8 busy start
    run_op(2'd0, 16'h8B16, 8'h7C, 8'h01, 8'h31, 8'h02, 8'h00, 1'b1); // R8 busy start, read

    repeat (4) @(posedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, queue=%0d expected 0", exp_q.size());
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule